// File: doc/BRIEF.md
# I2C Bus Event Trigger

This block watches the two lines of an I2C bus from the inside of a chip and raises a single-cycle trigger when a selected bus event goes past. It is purely an observer: both lines enter as inputs, pass through two-flop synchronisers, and are oversampled by the much faster system clock. A line change is found by comparing the current synchronised sample with the one before it. The block never drives either line.

Software-free configuration inputs choose the event type. The choices are any start, a repeated start, a stop, a missing acknowledge, an address (7-bit or 10-bit, optionally qualified by the R/W bit), a run of consecutive data bytes, or an address followed by a data run within the same transfer. A small status output holds the most recently decoded address, its R/W bit and whether it was a 10-bit address. Typical uses are capture logic, debug counters, or an interrupt that fires on one precise bus transaction.

Top module: `i2c_evt_trig`

## Requirements
- R1: With `trigSel` = 0, every start condition (SDA falling while SCL is high), including a repeated start, produces one `trigPulse`.
- R2: With `trigSel` = 2, every stop condition (SDA rising while SCL is high) produces one `trigPulse`, and the decoder returns to idle.
- R3: With `trigSel` = 1, `trigPulse` fires only for a start that follows an earlier start with no stop between them. A first start after idle does not fire.
- R4: Bits are taken on SCL rising edges, most significant bit first, with the ninth bit of each byte being the acknowledge slot. With `trigSel` = 4 and `addrTen` = 0, the pulse fires in the address acknowledge slot when the first byte's upper seven bits equal `addrVal[6:0]`.
- R5: A first byte whose upper five bits are 11110 starts a 10-bit address. Its bits 2:1 become address bits 9:8 and its bit 0 is the R/W bit. The next byte supplies address bits 7:0. With `trigSel` = 4 and `addrTen` = 1, the pulse fires in the second byte's acknowledge slot when the 10-bit address equals `addrVal`.
- R6: When `rwCare` = 1, an address match also requires the R/W bit to equal `rwVal` (1 = read). When `rwCare` = 0, the R/W bit is ignored.
- R7: With `trigSel` = 3, every acknowledge slot sampled high, whether after an address byte or a data byte, produces one `trigPulse`.
- R8: With `trigSel` = 5, the pulse fires when `dataCnt` consecutive data bytes equal the pattern, where pattern byte k is `dataPat[8k+7:8k]` and byte 0 is the first on the bus. Only `dataCnt` values from 1 to MAX_BYTES are valid; any other value never fires. After a full match the compare starts afresh.
- R9: On a data byte that breaks a partial match, the compare restarts, and that same byte is tried as pattern byte 0.
- R10: With `trigSel` = 6, the data pattern fires only inside a transfer whose address matched under R4 to R6.
- R11: Any start or stop discards a partial data match and the partial byte, and the address phase begins anew after a start.
- R12: `statAddr`, `statRw` and `statTen` reset to zero and change only when an address completes. They then hold the new address (zero-extended for 7-bit), its R/W bit, and 1 for a 10-bit address.
- R13: `trigPulse` is zero after reset and never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| trigSel | input | 3 | Event type: 0 start, 1 repeated start, 2 stop, 3 missing ack, 4 address, 5 data, 6 address+data, 7 none |
| addrVal | input | 10 | Address to match (bits 6:0 in 7-bit mode) |
| addrTen | input | 1 | 1 selects 10-bit address matching |
| rwCare | input | 1 | 1 qualifies address matches on R/W |
| rwVal | input | 1 | Required R/W bit when qualified |
| dataPat | input | 8*MAX_BYTES | Data pattern, byte 0 in the lowest bits |
| dataCnt | input | clog2(MAX_BYTES+1) | Number of pattern bytes to match |
| trigPulse | output | 1 | One-cycle trigger |
| statAddr | output | 10 | Last decoded address |
| statRw | output | 1 | R/W bit of last decoded address |
| statTen | output | 1 | Last decoded address was 10-bit |

## Verification
The bench drives whole bus transfers and counts trigger pulses per scenario. It distinguishes a first start from a repeated one; a design that ignores the stop between them would fire the repeated-start trigger on every start. It sends addresses that differ only in the R/W bit and 10-bit addresses that differ only in their low byte, so loose compares or a missed prefix show up as extra or missing pulses. Data runs are checked with reversed order, a repeated first byte, and a stop or repeated start splitting the run. A design that did not retry the breaking byte, or that kept partial matches across a start or stop, would miscount. The status word is checked after 7-bit and 10-bit addresses.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

  typedef enum logic [2:0] {
    TRG_START    = 3'd0,
    TRG_REPSTART = 3'd1,
    TRG_STOP     = 3'd2,
    TRG_NOACK    = 3'd3,
    TRG_ADDR     = 3'd4,
    TRG_DATA     = 3'd5,
    TRG_ADDRDATA = 3'd6,
    TRG_NONE     = 3'd7
  } trigSel_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR1 = 2'd1,
    PH_ADDR2 = 2'd2,
    PH_DATA  = 2'd3
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftBit;     // shift sampled SDA into the byte register
    logic latchHi;      // keep 10-bit prefix bits and R/W
    logic commit7;      // complete a 7-bit address
    logic commit10;     // complete a 10-bit address
    logic matchAdv;     // advance data pattern index
    logic matchRestart; // retry current byte as pattern byte 0
    logic matchClr;     // drop any partial data match
  } ctrlStrobe_t;

  localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;
  localparam int unsigned ACK_SLOT = 8;

endpackage

// File: rtl/i2c_evt_dp.sv
module i2c_evt_dp
  import i2c_evt_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W = $clog2(MAX_BYTES + 1),
  localparam int unsigned IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  input  logic [9:0]             addrVal,
  input  logic                   addrTen,
  input  logic                   rwCare,
  input  logic                   rwVal,
  input  logic [8*MAX_BYTES-1:0] dataPat,
  input  logic [CNT_W-1:0]       dataCnt,
  input  ctrlStrobe_t            strb,
  output logic                   evStart,
  output logic                   evStop,
  output logic                   sclRise,
  output logic                   sdaBit,
  output logic                   prefix10,
  output logic                   addrHit7,
  output logic                   addrHit10,
  output logic                   patHit,
  output logic                   patFull,
  output logic                   firstFull,
  output logic [9:0]             statAddr,
  output logic                   statRw,
  output logic                   statTen
);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclNow, sdaNow, sclPrev, sdaPrev;
  logic [7:0] shiftReg;
  logic [1:0] hiBits;
  logic rwHi;
  logic [IDX_W-1:0] matchCnt;
  logic [7:0] patByte [MAX_BYTES];
  logic cfgOk, firstHit;

  // synchronisers, idle-high reset so no false edge leaves reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow  = sclSync[SYNC_STAGES-1];
  assign sdaNow  = sdaSync[SYNC_STAGES-1];
  assign evStart = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign evStop  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign sclRise = sclNow & ~sclPrev;
  assign sdaBit  = sdaNow;

  // byte register and address parts
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      hiBits   <= '0;
      rwHi     <= 1'b0;
    end else begin
      if (strb.shiftBit) shiftReg <= {shiftReg[6:0], sdaNow};
      if (strb.latchHi) begin
        hiBits <= shiftReg[2:1];
        rwHi   <= shiftReg[0];
      end
    end
  end

  assign prefix10  = (shiftReg[7:3] == TEN_BIT_PREFIX);
  assign addrHit7  = !addrTen && (shiftReg[7:1] == addrVal[6:0]) &&
                     (!rwCare || (shiftReg[0] == rwVal));
  assign addrHit10 = addrTen && ({hiBits, shiftReg} == addrVal) &&
                     (!rwCare || (rwHi == rwVal));

  // status word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statAddr <= '0;
      statRw   <= 1'b0;
      statTen  <= 1'b0;
    end else if (strb.commit7) begin
      statAddr <= {3'b000, shiftReg[7:1]};
      statRw   <= shiftReg[0];
      statTen  <= 1'b0;
    end else if (strb.commit10) begin
      statAddr <= {hiBits, shiftReg};
      statRw   <= rwHi;
      statTen  <= 1'b1;
    end
  end

  // pattern bytes, byte 0 first on the bus
  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_pat
    assign patByte[k] = dataPat[8*k +: 8];
  end

  assign cfgOk     = (dataCnt != '0) && (dataCnt <= CNT_W'(MAX_BYTES));
  assign patHit    = cfgOk && (shiftReg == patByte[matchCnt]);
  assign patFull   = patHit && ((CNT_W'(matchCnt) + CNT_W'(1)) == dataCnt);
  assign firstHit  = cfgOk && (shiftReg == patByte[0]);
  assign firstFull = firstHit && (dataCnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchCnt <= '0;
    end else if (strb.matchClr) begin
      matchCnt <= '0;
    end else if (strb.matchAdv) begin
      matchCnt <= matchCnt + IDX_W'(1);
    end else if (strb.matchRestart) begin
      matchCnt <= firstHit ? IDX_W'(1) : '0;
    end
  end

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (evStart || evStop) |=> (matchCnt == '0)); // R11

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.commit7 || strb.commit10) |=> $stable(statAddr) && $stable(statTen)); // R12

  AST_START_NOT_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (evStart || evStop) |-> !sclRise); // R4

endmodule

// File: rtl/i2c_evt_ctrl.sv
module i2c_evt_ctrl
  import i2c_evt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  trigSel,
  input  logic        evStart,
  input  logic        evStop,
  input  logic        sclRise,
  input  logic        sdaBit,
  input  logic        prefix10,
  input  logic        addrHit7,
  input  logic        addrHit10,
  input  logic        patHit,
  input  logic        patFull,
  input  logic        firstFull,
  output ctrlStrobe_t strb,
  output logic        trigPulse
);

  phase_t phase, phaseNext;
  logic [3:0] bitCnt, bitCntNext;
  logic busy, busyNext;
  logic addrOk, addrOkNext;
  logic fire;
  logic dataFire;

  assign dataFire = (trigSel == TRG_DATA) || ((trigSel == TRG_ADDRDATA) && addrOk);

  always_comb begin
    strb       = '0;
    fire       = 1'b0;
    phaseNext  = phase;
    bitCntNext = bitCnt;
    busyNext   = busy;
    addrOkNext = addrOk;
    if (evStart) begin
      fire = (trigSel == TRG_START) || ((trigSel == TRG_REPSTART) && busy);
      busyNext      = 1'b1;
      phaseNext     = PH_ADDR1;
      bitCntNext    = '0;
      addrOkNext    = 1'b0;
      strb.matchClr = 1'b1;
    end else if (evStop) begin
      fire          = (trigSel == TRG_STOP);
      busyNext      = 1'b0;
      phaseNext     = PH_IDLE;
      bitCntNext    = '0;
      addrOkNext    = 1'b0;
      strb.matchClr = 1'b1;
    end else if (sclRise && (phase != PH_IDLE)) begin
      if (bitCnt != 4'(ACK_SLOT)) begin
        strb.shiftBit = 1'b1;
        bitCntNext    = bitCnt + 4'd1;
      end else begin
        bitCntNext = '0;
        if (sdaBit && (trigSel == TRG_NOACK)) fire = 1'b1;
        unique case (phase)
          PH_ADDR1: begin
            if (prefix10) begin
              strb.latchHi = 1'b1;
              phaseNext    = PH_ADDR2;
            end else begin
              strb.commit7 = 1'b1;
              addrOkNext   = addrHit7;
              if (addrHit7 && (trigSel == TRG_ADDR)) fire = 1'b1;
              phaseNext    = PH_DATA;
            end
          end
          PH_ADDR2: begin
            strb.commit10 = 1'b1;
            addrOkNext    = addrHit10;
            if (addrHit10 && (trigSel == TRG_ADDR)) fire = 1'b1;
            phaseNext     = PH_DATA;
          end
          PH_DATA: begin
            if (patHit) begin
              if (patFull) begin
                if (dataFire) fire = 1'b1;
                strb.matchClr = 1'b1;
              end else begin
                strb.matchAdv = 1'b1;
              end
            end else if (firstFull) begin
              if (dataFire) fire = 1'b1;
              strb.matchClr = 1'b1;
            end else begin
              strb.matchRestart = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      bitCnt    <= '0;
      busy      <= 1'b0;
      addrOk    <= 1'b0;
      trigPulse <= 1'b0;
    end else begin
      phase     <= phaseNext;
      bitCnt    <= bitCntNext;
      busy      <= busyNext;
      addrOk    <= addrOkNext;
      trigPulse <= fire;
    end
  end

  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'(ACK_SLOT)); // R4

  AST_REP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (evStart && (trigSel == TRG_REPSTART) && !busy) |=> !trigPulse); // R3

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    evStop |=> (phase == PH_IDLE) && !busy); // R2

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse); // R13

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> !strb.shiftBit); // R11

endmodule

// File: rtl/i2c_evt_trig.sv
module i2c_evt_trig
  import i2c_evt_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 4,
  localparam int unsigned CNT_W = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  input  logic [2:0]             trigSel,
  input  logic [9:0]             addrVal,
  input  logic                   addrTen,
  input  logic                   rwCare,
  input  logic                   rwVal,
  input  logic [8*MAX_BYTES-1:0] dataPat,
  input  logic [CNT_W-1:0]       dataCnt,
  output logic                   trigPulse,
  output logic [9:0]             statAddr,
  output logic                   statRw,
  output logic                   statTen
);

  ctrlStrobe_t strb;
  logic evStart, evStop, sclRise, sdaBit, prefix10;
  logic addrHit7, addrHit10, patHit, patFull, firstFull;

  i2c_evt_dp #(.MAX_BYTES(MAX_BYTES), .SYNC_STAGES(2)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrVal(addrVal), .addrTen(addrTen), .rwCare(rwCare), .rwVal(rwVal),
    .dataPat(dataPat), .dataCnt(dataCnt), .strb(strb),
    .evStart(evStart), .evStop(evStop), .sclRise(sclRise), .sdaBit(sdaBit),
    .prefix10(prefix10), .addrHit7(addrHit7), .addrHit10(addrHit10),
    .patHit(patHit), .patFull(patFull), .firstFull(firstFull),
    .statAddr(statAddr), .statRw(statRw), .statTen(statTen)
  );

  i2c_evt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .trigSel(trigSel),
    .evStart(evStart), .evStop(evStop), .sclRise(sclRise), .sdaBit(sdaBit),
    .prefix10(prefix10), .addrHit7(addrHit7), .addrHit10(addrHit10),
    .patHit(patHit), .patFull(patFull), .firstFull(firstFull),
    .strb(strb), .trigPulse(trigPulse)
  );

endmodule

// File: tb/i2c_evt_trig_tb.sv
module i2c_evt_trig_tb_top;

  localparam int unsigned MAXB = 4;
  localparam int unsigned CW = $clog2(MAXB + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic [2:0] trigSel = 3'd7;
  logic [9:0] addrVal = '0;
  logic addrTen = 1'b0, rwCare = 1'b0, rwVal = 1'b0;
  logic [8*MAXB-1:0] dataPat = '0;
  logic [CW-1:0] dataCnt = '0;
  logic trigPulse, statRw, statTen;
  logic [9:0] statAddr;

  int checks = 0, errors = 0;
  int pulseCnt = 0, wideCnt = 0;
  logic prevHigh = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  i2c_evt_trig #(.MAX_BYTES(MAXB)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sda), .trigSel(trigSel),
    .addrVal(addrVal), .addrTen(addrTen), .rwCare(rwCare), .rwVal(rwVal),
    .dataPat(dataPat), .dataCnt(dataCnt), .trigPulse(trigPulse),
    .statAddr(statAddr), .statRw(statRw), .statTen(statTen)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (trigPulse) pulseCnt++;
      if (trigPulse && prevHigh) wideCnt++;
      prevHigh = trigPulse;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic busStart();
    sda = 1'b1; waitClk(4);
    scl = 1'b1; waitClk(6);
    sda = 1'b0; waitClk(6);
    scl = 1'b0; waitClk(4);
  endtask

  task automatic busStop();
    sda = 1'b0; waitClk(4);
    scl = 1'b1; waitClk(6);
    sda = 1'b1; waitClk(8);
  endtask

  task automatic sendBit(input logic b);
    sda = b; waitClk(4);
    scl = 1'b1; waitClk(8);
    scl = 1'b0; waitClk(4);
  endtask

  // nack = 1 leaves the acknowledge slot high
  task automatic sendByte(input logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sendBit(nack);
  endtask

  task automatic beginCase(input logic [2:0] sel);
    trigSel = sel;
    waitClk(4);
    pulseCnt = 0;
  endtask

  task automatic endCount(input string req, input int exp);
    waitClk(10);
    check(req, pulseCnt, exp);
  endtask

  task automatic tReset();
    check("R13 reset pulse", int'(trigPulse), 0);
    check("R12 reset addr", int'(statAddr), 0);
    check("R12 reset rw/ten", int'({statRw, statTen}), 0);
  endtask

  task automatic tStart();
    beginCase(3'd0);
    busStart(); sendByte(8'hA0, 1'b0);
    busStart(); sendByte(8'hA1, 1'b0); busStop();
    endCount("R1 start count", 2);
  endtask

  task automatic tRepStart();
    beginCase(3'd1);
    busStart(); sendByte(8'hA0, 1'b0); busStop();
    busStart(); sendByte(8'hA0, 1'b0);
    busStart(); sendByte(8'hA1, 1'b0); busStop();
    endCount("R3 repeated start count", 1);
  endtask

  task automatic tStop();
    beginCase(3'd2);
    busStart(); sendByte(8'hA0, 1'b0); busStop();
    busStart(); sendByte(8'h20, 1'b0); sendByte(8'h55, 1'b0); busStop();
    endCount("R2 stop count", 2);
  endtask

  task automatic tAddr7();
    addrVal = 10'h050; addrTen = 1'b0; rwCare = 1'b0;
    beginCase(3'd4);
    busStart(); sendByte(8'hA0, 1'b0); busStop();
    busStart(); sendByte(8'hA2, 1'b0); busStop();
    busStart(); sendByte(8'hA1, 1'b0); sendByte(8'hA0, 1'b1); busStop();
    endCount("R4 7-bit address count", 2);
    check("R12 status addr", int'(statAddr), 'h50);
    check("R12 status rw", int'(statRw), 1);
    check("R12 status ten", int'(statTen), 0);
  endtask

  task automatic tRwQual();
    addrVal = 10'h050; addrTen = 1'b0; rwCare = 1'b1; rwVal = 1'b0;
    beginCase(3'd4);
    busStart(); sendByte(8'hA0, 1'b0); busStop();
    busStart(); sendByte(8'hA1, 1'b0); busStop();
    endCount("R6 write-qualified count", 1);
    rwVal = 1'b1;
    beginCase(3'd4);
    busStart(); sendByte(8'hA0, 1'b0); busStop();
    busStart(); sendByte(8'hA1, 1'b0); busStop();
    busStart(); sendByte(8'hA1, 1'b0); busStop();
    endCount("R6 read-qualified count", 2);
    rwCare = 1'b0;
  endtask

  task automatic tAddr10();
    addrVal = 10'h2A5; addrTen = 1'b1; rwCare = 1'b0;
    beginCase(3'd4);
    busStart(); sendByte(8'hF4, 1'b0); sendByte(8'hA4, 1'b0); busStop();
    busStart(); sendByte(8'hF2, 1'b0); sendByte(8'hA5, 1'b0); busStop();
    busStart(); sendByte(8'h4A, 1'b0); busStop();
    busStart(); sendByte(8'hF4, 1'b0); sendByte(8'hA5, 1'b0); busStop();
    endCount("R5 10-bit address count", 1);
    check("R12 status 10-bit addr", int'(statAddr), 'h2A5);
    check("R12 status 10-bit ten/rw", int'({statTen, statRw}), 2);
    addrTen = 1'b0;
  endtask

  task automatic tNoAck();
    beginCase(3'd3);
    busStart(); sendByte(8'hA0, 1'b0); sendByte(8'h11, 1'b0); sendByte(8'h22, 1'b1); busStop();
    busStart(); sendByte(8'hB0, 1'b1); busStop();
    endCount("R7 missing ack count", 2);
  endtask

  task automatic tData();
    dataPat = {16'h0, 8'h2C, 8'h16}; dataCnt = CW'(2);
    beginCase(3'd5);
    busStart(); sendByte(8'hA0, 1'b0); sendByte(8'h16, 1'b0); sendByte(8'h2C, 1'b0); busStop();
    busStart(); sendByte(8'hA0, 1'b0); sendByte(8'h2C, 1'b0); sendByte(8'h16, 1'b0); busStop();
    endCount("R8 two-byte pattern count", 1);
    dataCnt = '0;
    beginCase(3'd5);
    busStart(); sendByte(8'hA0, 1'b0); sendByte(8'h16, 1'b0); sendByte(8'h2C, 1'b0); busStop();
    endCount("R8 zero count never fires", 0);
  endtask

  task automatic tRestart();
    dataPat = {16'h0, 8'h22, 8'h11}; dataCnt = CW'(2);
    beginCase(3'd5);
    busStart(); sendByte(8'hA0, 1'b0);
    sendByte(8'h11, 1'b0); sendByte(8'h11, 1'b0); sendByte(8'h22, 1'b0); busStop();
    endCount("R9 restart on breaking byte", 1);
  endtask

  task automatic tAddrData();
    addrVal = 10'h050; addrTen = 1'b0; rwCare = 1'b1; rwVal = 1'b0;
    dataPat = {24'h0, 8'hA5}; dataCnt = CW'(1);
    beginCase(3'd6);
    busStart(); sendByte(8'hA0, 1'b0); sendByte(8'hA5, 1'b0); busStop();
    busStart(); sendByte(8'hA2, 1'b0); sendByte(8'hA5, 1'b0); busStop();
    busStart(); sendByte(8'hA1, 1'b0); sendByte(8'hA5, 1'b0); busStop();
    endCount("R10 address+data count", 1);
    rwCare = 1'b0;
  endtask

  task automatic tAbort();
    dataPat = {16'h0, 8'h22, 8'h11}; dataCnt = CW'(2);
    beginCase(3'd5);
    busStart(); sendByte(8'hA0, 1'b0); sendByte(8'h11, 1'b0); busStop();
    busStart(); sendByte(8'hA0, 1'b0); sendByte(8'h22, 1'b0);
    sendByte(8'h11, 1'b0);
    busStart(); sendByte(8'hA0, 1'b0); sendByte(8'h22, 1'b0); busStop();
    endCount("R11 start/stop abort partial match", 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    tReset();
    tStart();
    tRepStart();
    tStop();
    tAddr7();
    tRwQual();
    tAddr10();
    tNoAck();
    tData();
    tRestart();
    tAddrData();
    tAbort();
    check("R13 pulse width", wideCnt, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule